// File: doc/BRIEF.md
# Sequential/Non-Sequential Memory Cycle Controller

This block sits between a processor bus and a DRAM array. For every processor access it chooses the cycle type. A fast sequential cycle is used when the word address directly follows the last completed processor access. A slower non-sequential cycle is used for every other access. Word addresses are grouped into aligned lines of `LINE_WORDS` words. The first word of a line always gets a non-sequential cycle, so a long sequential burst is broken at every line start on purpose.

A second requester, such as a video refresh engine, asks for memory with its own address. It is only let in where a non-sequential cycle would begin. While the processor keeps running sequential cycles, the DMA requester waits. At a non-sequential point the DMA transfer wins, and the processor is held with ready low until the transfer is over. A DMA transfer breaks the address chain, so the next processor access runs non-sequentially.

Both requesters keep their request (and address) steady until they see their completion pulse, then drop it.

Top module: `memcyc_ctrl`

## Requirements
- R1: While reset is held and nothing is requested, `mem_strobe`, `cpu_ready` and `dma_grant` are low. The first processor access after reset is non-sequential.
- R2: A processor access whose word address equals the previous completed processor address plus one, and that is not a line start, completes in one clock. In that clock `cpu_ready` and `mem_seq` are high.
- R3: Any other processor access takes `NS_CLKS` clocks (default 2), with `mem_seq` low. `cpu_ready` is high only in the last of them.
- R4: A word address whose low log2(`LINE_WORDS`) bits are zero always runs non-sequentially. This includes wrap-around from all ones to zero. With the defaults (4-byte words, 4-word lines) this is any byte address that is a multiple of 16.
- R5: A pending DMA request is not served while the processor's pending access qualifies as sequential. The processor access completes first, in one clock, and the DMA transfer follows it.
- R6: When a DMA request is pending at a non-sequential point, the DMA transfer goes first. It takes `DMA_CLKS` clocks (default 2) with `mem_dma` high, `mem_addr` equal to `dma_addr` and `mem_we` low. `dma_grant` is high in its last clock. Any processor access waits with `cpu_ready` low.
- R7: The processor access that follows a completed DMA transfer is non-sequential, even if its address follows the previous processor address.
- R8: During processor cycles `mem_addr` equals `cpu_addr` and `mem_we` equals `cpu_we`. `cpu_ready` and `dma_grant` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_addr | input | AW | Processor word address |
| cpu_we | input | 1 | Processor write enable |
| cpu_ready | output | 1 | Processor access completes this clock |
| dma_req | input | 1 | DMA request, held until `dma_grant` |
| dma_addr | input | AW | DMA word address |
| dma_grant | output | 1 | DMA transfer completes this clock |
| mem_strobe | output | 1 | Memory cycle active this clock |
| mem_seq | output | 1 | Current memory cycle is sequential |
| mem_dma | output | 1 | Current memory cycle belongs to DMA |
| mem_addr | output | AW | Word address presented to memory |
| mem_we | output | 1 | Write enable presented to memory |

## Verification
The hardest situation to reach is a DMA request arriving in the middle of a running sequential burst. The request must then wait through every remaining in-line word and be taken only at the next line start. The bench builds this directly. It starts a run of consecutive addresses, raises the DMA request beside a sequential access, and checks that the processor still finishes in one clock and the transfer comes after it. Random stimulus biases most addresses toward the next word, so runs often cross line starts and often collide with DMA. Directed cases cover the wrap from all-ones to zero and the address that follows a DMA transfer.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   // Controller phase: idle is the only point where a new cycle is chosen
   typedef enum logic [1:0] {
      MC_IDLE = 2'd0,
      MC_CPU  = 2'd1,
      MC_DMA  = 2'd2
   } mc_state_e;

endpackage

// File: rtl/mcc_seq_track.sv
module mcc_seq_track #(
   parameter int AW         = 30,
   parameter int LINE_WORDS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          cpu_done,
   input  logic          dma_done,
   output logic          seq_ok
);

   localparam int LB      = $clog2(LINE_WORDS);
   localparam int LB_SAFE = (LB == 0) ? 1 : LB;

   logic [AW-1:0] prev_q;
   logic          valid_q;
   logic          at_line;
   logic [AW-1:0] follow;

   // Previous address moves only on processor completions; DMA breaks the chain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         valid_q <= 1'b0;
      end else if (cpu_done) begin
         prev_q  <= addr;
         valid_q <= 1'b1;
      end else if (dma_done) begin
         valid_q <= 1'b0;
      end
   end

   generate
      if (LINE_WORDS == 1) begin : g_every_word
         assign at_line = 1'b1;
      end else begin : g_line
         assign at_line = (addr[LB_SAFE-1:0] == '0);
      end
   endgenerate

   assign follow = prev_q + 1'b1;
   assign seq_ok = valid_q && (addr == follow) && !at_line;

   // R7
   dma_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done && !cpu_done) |=> !seq_ok);

endmodule

// File: rtl/mcc_timer.sv
module mcc_timer #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic last
);

   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   assign last = run && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (start)  cnt_q <= CW'(1);
      else if (last)   cnt_q <= '0;
      else if (run)    cnt_q <= cnt_q + 1'b1;
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(LIMIT));

endmodule

// File: rtl/memcyc_ctrl.sv
module memcyc_ctrl
   import mcc_pkg::*;
#(
   parameter int AW         = 30,
   parameter int LINE_WORDS = 4,
   parameter int NS_CLKS    = 2,
   parameter int DMA_CLKS   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_we,
   output logic          cpu_ready,
   input  logic          dma_req,
   input  logic [AW-1:0] dma_addr,
   output logic          dma_grant,
   output logic          mem_strobe,
   output logic          mem_seq,
   output logic          mem_dma,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we
);

   generate
      if (NS_CLKS < 2) begin : g_bad_ns
         initial $error("NS_CLKS must be at least 2");
      end
      if (DMA_CLKS < 2) begin : g_bad_dma
         initial $error("DMA_CLKS must be at least 2");
      end
      if ((LINE_WORDS < 1) || ((LINE_WORDS & (LINE_WORDS - 1)) != 0)) begin : g_bad_line
         initial $error("LINE_WORDS must be a power of two");
      end
      if (AW < $clog2(LINE_WORDS) + 1) begin : g_bad_aw
         initial $error("AW too narrow for LINE_WORDS");
      end
   endgenerate

   mc_state_e state_q, state_d;
   logic      seq_ok;
   logic      cpu_start, dma_start;
   logic      cpu_last, dma_last;

   mcc_seq_track #(.AW(AW), .LINE_WORDS(LINE_WORDS)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (cpu_addr),
      .cpu_done (cpu_ready),
      .dma_done (dma_grant),
      .seq_ok   (seq_ok)
   );

   mcc_timer #(.LIMIT(NS_CLKS)) u_cpu_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cpu_start),
      .run   (state_q == MC_CPU),
      .last  (cpu_last)
   );

   mcc_timer #(.LIMIT(DMA_CLKS)) u_dma_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (dma_start),
      .run   (state_q == MC_DMA),
      .last  (dma_last)
   );

   // Decision order at idle: sequential processor access, then DMA, then a
   // non-sequential processor access.
   always_comb begin
      state_d    = state_q;
      cpu_start  = 1'b0;
      dma_start  = 1'b0;
      cpu_ready  = 1'b0;
      dma_grant  = 1'b0;
      mem_strobe = 1'b0;
      mem_seq    = 1'b0;
      mem_dma    = 1'b0;
      mem_addr   = cpu_addr;
      mem_we     = 1'b0;
      unique case (state_q)
         MC_IDLE: begin
            if (cpu_req && seq_ok) begin
               mem_strobe = 1'b1;
               mem_seq    = 1'b1;
               mem_we     = cpu_we;
               cpu_ready  = 1'b1;
            end else if (dma_req) begin
               mem_strobe = 1'b1;
               mem_dma    = 1'b1;
               mem_addr   = dma_addr;
               dma_start  = 1'b1;
               state_d    = MC_DMA;
            end else if (cpu_req) begin
               mem_strobe = 1'b1;
               mem_we     = cpu_we;
               cpu_start  = 1'b1;
               state_d    = MC_CPU;
            end
         end
         MC_CPU: begin
            mem_strobe = 1'b1;
            mem_we     = cpu_we;
            if (cpu_last) begin
               cpu_ready = 1'b1;
               state_d   = MC_IDLE;
            end
         end
         MC_DMA: begin
            mem_strobe = 1'b1;
            mem_dma    = 1'b1;
            mem_addr   = dma_addr;
            if (dma_last) begin
               dma_grant = 1'b1;
               state_d   = MC_IDLE;
            end
         end
         default: state_d = MC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= MC_IDLE;
      else        state_q <= state_d;
   end

   // Tracks a DMA completion not yet followed by a processor completion
   logic after_dma_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         after_dma_q <= 1'b0;
      else if (dma_grant) after_dma_q <= 1'b1;
      else if (cpu_ready) after_dma_q <= 1'b0;
   end

   // R2
   seq_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_seq |-> (cpu_ready && !mem_dma));

   // R3
   nseq_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !mem_seq) |-> $past(mem_strobe && !mem_dma && !cpu_ready));

   // R6
   dma_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_grant |-> (mem_dma && !mem_we && $past(mem_dma)));

   // R7
   after_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      after_dma_q |-> !mem_seq);

   // R8
   one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_ready, dma_grant}));

endmodule

// File: tb/memcyc_ctrl_test.sv
module memcyc_ctrl_test;

   localparam int AW   = 30;
   localparam int NS   = 2;
   localparam int DMAC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_we = 1'b0;
   logic          cpu_ready;
   logic          dma_req = 1'b0;
   logic [AW-1:0] dma_addr = '0;
   logic          dma_grant;
   logic          mem_strobe, mem_seq, mem_dma, mem_we;
   logic [AW-1:0] mem_addr;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [AW-1:0] m_prev = '0;
   bit            m_valid = 1'b0;

   always #10 clk = ~clk;

   memcyc_ctrl #(.AW(AW), .LINE_WORDS(4), .NS_CLKS(NS), .DMA_CLKS(DMAC)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
      .dma_req(dma_req), .dma_addr(dma_addr), .dma_grant(dma_grant),
      .mem_strobe(mem_strobe), .mem_seq(mem_seq), .mem_dma(mem_dma),
      .mem_addr(mem_addr), .mem_we(mem_we)
   );

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_seq(logic [AW-1:0] a);
      return m_valid && (a == AW'(m_prev + 1)) && (a[1:0] != 2'b00);
   endfunction

   // Called at a falling edge; returns at a falling edge with both requests low
   task automatic run_op(bit cg, logic [AW-1:0] a, bit w, bit dg, logic [AW-1:0] da,
                         string rq);
      int cyc = 0, cclk = 0, dclk = 0, ecclk = 0, edclk = 0;
      bit cdone = !cg, ddone = !dg, cseq = 0, cwe = 0, aerr = 0, ecseq = 0;
      bit s;
      s = cg && exp_seq(a);
      cpu_req = cg; cpu_addr = a; cpu_we = w;
      dma_req = dg; dma_addr = da;
      while (!(cdone && ddone) && cyc < 50) begin
         #1;
         cyc++;
         if (mem_strobe) begin
            if (mem_dma) begin
               if (mem_addr != da || mem_we) aerr = 1;
            end else if (mem_addr != a || mem_we != w) aerr = 1;
         end
         if (cpu_ready && !cdone) begin cclk = cyc; cseq = mem_seq; cwe = mem_we; cdone = 1; end
         if (dma_grant && !ddone) begin dclk = cyc; ddone = 1; end
         @(negedge clk);
         if (cdone) cpu_req = 1'b0;
         if (ddone) dma_req = 1'b0;
      end
      if (s) begin
         ecclk = 1; ecseq = 1;
         edclk = dg ? 1 + DMAC : 0;
         m_prev = a; m_valid = !dg;
      end else if (dg) begin
         edclk = DMAC;
         if (cg) begin ecclk = DMAC + NS; m_prev = a; m_valid = 1; end
         else m_valid = 0;
      end else if (cg) begin
         ecclk = NS; m_prev = a; m_valid = 1;
      end
      if (cg) begin
         chk(cclk == ecclk, {rq, " cpu clocks"}, cclk, ecclk);
         chk(cseq == ecseq, {rq, " mem_seq"}, cseq, ecseq);
         chk(cwe == w, "R8 mem_we at ready", cwe, w);
      end
      if (dg) chk(dclk == edclk, {rq, " dma clocks"}, dclk, edclk);
      chk(!aerr, "R8/R6 address and write routing", aerr, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7731));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(!mem_strobe && !cpu_ready && !dma_grant, "R1 reset outputs",
          {mem_strobe, cpu_ready, dma_grant}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(1, 30'd8,  0, 0, '0, "R1 first access");
      run_op(1, 30'd9,  0, 0, '0, "R2 seq");
      run_op(1, 30'd10, 1, 0, '0, "R2 seq write");
      run_op(1, 30'd11, 0, 0, '0, "R2 seq");
      run_op(1, 30'd12, 0, 0, '0, "R4 line start");
      run_op(1, 30'd13, 1, 0, '0, "R2 seq");
      run_op(1, 30'd14, 0, 1, 30'h100, "R5 dma behind seq");
      run_op(1, 30'd15, 0, 1, 30'h104, "R6 dma first");
      run_op(0, '0,     0, 1, 30'h200, "R6 dma alone");
      run_op(1, 30'd17, 0, 0, '0, "R7 after dma");
      run_op(1, 30'd18, 0, 0, '0, "R2 seq");
      run_op(0, '0,     0, 1, 30'h300, "R6 dma alone");
      run_op(1, 30'd19, 0, 0, '0, "R7 after dma");
      run_op(1, 30'd20, 0, 1, 30'h304, "R4/R6 line start with dma");
      run_op(1, {AW{1'b1}}, 0, 0, '0, "R3 nonseq");
      run_op(1, '0,         0, 0, '0, "R4 wrap");
      run_op(1, 30'd1,      0, 0, '0, "R2 seq");
      for (int i = 0; i < 300; i++) begin
         int r;
         bit cg, dg, w;
         logic [AW-1:0] a;
         r  = int'($urandom_range(0, 9));
         cg = ($urandom_range(0, 9) != 0);
         dg = ($urandom_range(0, 3) == 0);
         w  = $urandom_range(0, 1) != 0;
         a  = (r < 7) ? AW'(m_prev + 1) : AW'($urandom_range(0, 255));
         if (!cg && !dg) cg = 1;
         run_op(cg, a, w, dg, AW'($urandom_range(0, 1023)), "R2/R3/R5/R6 random");
      end
      #1;
      chk(!mem_strobe, "R1 idle after run", mem_strobe, 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule